// File: doc/BRIEF.md
# Frame Process Display Scheduler

This block sequences an interlaced video change detector. It keeps the detector in one of three activities, idle, process or display, and, while busy, walks the address space of a frame memory. That memory packs two neighbouring 8-bit pixels into each 16-bit word and is arranged by field, line within the field, and pixel column. In the process activity each word is read and then written back at the same address, with the processing path enabled. In the display activity each word is read once, with the encoder path enabled. The odd field is always walked before the even field.

Input frames arrive from the video decoder at a fixed rate, signalled by a one-cycle start strobe. The scheduler numbers the frames modulo the input rate, so each count cycle is one second. It grants at most a per-second budget of frames, equal to the smaller of the requested rate and a hard ceiling, and stays idle for the rest of each second. A start strobe that arrives while the scheduler is busy is dropped, but it still advances the frame count.

Top module: `frame_sched`

## Requirements
- R1: While reset is high and in the first cycle after it, `sched_state` is 0, all four strobes are low and `mem_addr` is 0.
- R2: `sched_state` encodes idle=0, process=1, display=2. After a granted start the states run process, then display, then idle. In idle no strobe is high, and `proc_en` and `enc_en` are never high together.
- R3: `mem_addr` bit 18 is the field (0 = odd, walked first). Bits 17:10 are the line within the field and bits 9:0 are the pixel column, always even. The walk steps the column by 2 from 0 to COLS-2, then moves to the next line, then to the next field.
- R4: In process, every word takes two cycles: a cycle with `mem_rd` high, then a cycle with `mem_wr` high at the same address. `proc_en` stays high for all 2·(2·FIELD_LINES·COLS/2) cycles.
- R5: In display, every word takes one cycle with `mem_rd` high, `mem_wr` low and `enc_en` high. The walk starts at address 0.
- R6: A `frame_sof` sampled high in idle with budget left moves the block to process in the next cycle, at address 0.
- R7: A `frame_sof` sampled high during process or display has no effect on the walk, but still counts as an input frame.
- R8: Input frames are numbered modulo 30, and the first strobe after reset is frame 0. The per-second grant count restarts at frame 0.
- R9: `req_fps` is sampled with each strobe. A frame is granted only if fewer than min(`req_fps`, 15) frames have been granted so far in the current second, so a request above 15 yields 15.
- R10: With `req_fps` = 0 no frame is processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_sof | input | 1 | One-cycle strobe at the start of each input frame |
| req_fps | input | 5 | Requested processed frames per second |
| mem_addr | output | 19 | Word address: field, line, even pixel column |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| proc_en | output | 1 | Enables the processing path |
| enc_en | output | 1 | Enables the encoder path |
| sched_state | output | 2 | Current activity: 0 idle, 1 process, 2 display |

## Verification
The bench spaces strobes so that some land while the block is still busy. A design that restarted on those strobes would break the expected address stream. It also checks per-second grant totals for a request of 4, for a request of 20 that must be capped at 15, for a zero request, and for a request raised partway through a second. A budget that failed to restart at frame 0, or a missing ceiling, would show up as a wrong total. Every strobe cycle is compared to an expected read/write/address item, so a walk that put the even field first, stepped the column by 1, or skipped the write-back cycle would fail the comparison.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PROC = 2'd1,
    ST_DISP = 2'd2
  } sched_st_t;
endpackage

// File: rtl/rate_gate.sv
module rate_gate #(
  parameter int FPS_IN  = 30,
  parameter int FPS_MAX = 15,
  parameter int FPS_W   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sof,
  input  logic             idle,
  input  logic [FPS_W-1:0] req,
  output logic             grant
);
  localparam int IDX_W = $clog2(FPS_IN);

  logic [IDX_W-1:0] idx;
  logic [FPS_W-1:0] used;
  logic [FPS_W-1:0] cap;
  logic [FPS_W-1:0] base;

  // budget for the second: requested rate clipped at the ceiling
  assign cap   = (req > FPS_W'(FPS_MAX)) ? FPS_W'(FPS_MAX) : req;
  // frame 0 opens a fresh second
  assign base  = (idx == '0) ? '0 : used;
  assign grant = sof && idle && (base < cap);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx  <= '0;
      used <= '0;
    end else if (sof) begin
      idx  <= (idx == IDX_W'(FPS_IN - 1)) ? '0 : idx + 1'b1;
      used <= base + (grant ? FPS_W'(1) : FPS_W'(0));
    end
  end

  p_budget_cap_r9: assert property (@(posedge clk) disable iff (rst)
    used <= FPS_W'(FPS_MAX));
  p_second_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (sof && idx == '0) |=> used <= FPS_W'(1));
endmodule

// File: rtl/addr_walker.sv
module addr_walker #(
  parameter int COLS        = 640,
  parameter int FIELD_LINES = 240,
  parameter int COL_W       = 10,
  parameter int LINE_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              adv,
  output logic              fld,
  output logic [LINE_W-1:0] line,
  output logic [COL_W-1:0]  col,
  output logic              at_end
);
  localparam logic [COL_W-1:0]  LAST_COL  = COL_W'(COLS - 2);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(FIELD_LINES - 1);

  assign at_end = fld && (line == LAST_LINE) && (col == LAST_COL);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      fld  <= 1'b0;
      line <= '0;
      col  <= '0;
    end else if (adv) begin
      if (col == LAST_COL) begin
        col <= '0;
        if (line == LAST_LINE) begin
          line <= '0;
          fld  <= ~fld;
        end else begin
          line <= line + 1'b1;
        end
      end else begin
        col <= col + COL_W'(2);
      end
    end
  end

  p_addr_range_r3: assert property (@(posedge clk) disable iff (rst)
    (col < COL_W'(COLS)) && (line < LINE_W'(FIELD_LINES)));
endmodule

// File: rtl/frame_sched.sv
module frame_sched #(
  parameter int COLS        = 640,
  parameter int FIELD_LINES = 240,
  parameter int COL_W       = 10,
  parameter int LINE_W      = 8,
  parameter int FPS_IN      = 30,
  parameter int FPS_MAX     = 15,
  parameter int FPS_W       = 5,
  localparam int ADDR_W     = 1 + LINE_W + COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_sof,
  input  logic [FPS_W-1:0]  req_fps,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              proc_en,
  output logic              enc_en,
  output logic [1:0]        sched_state
);
  import sched_pkg::*;

  sched_st_t   st, st_n;
  logic        phase, phase_n;
  logic        clr, adv, grant, at_end;
  logic        fld;
  logic [LINE_W-1:0] line;
  logic [COL_W-1:0]  col;

  rate_gate #(.FPS_IN(FPS_IN), .FPS_MAX(FPS_MAX), .FPS_W(FPS_W)) u_gate (
    .clk(clk), .rst(rst), .sof(frame_sof), .idle(st == ST_IDLE),
    .req(req_fps), .grant(grant)
  );

  addr_walker #(.COLS(COLS), .FIELD_LINES(FIELD_LINES), .COL_W(COL_W),
                .LINE_W(LINE_W)) u_walk (
    .clk(clk), .rst(rst), .clear(clr), .adv(adv),
    .fld(fld), .line(line), .col(col), .at_end(at_end)
  );

  always_comb begin
    st_n    = st;
    phase_n = phase;
    clr     = 1'b0;
    adv     = 1'b0;
    case (st)
      ST_IDLE: if (grant) begin
        st_n    = ST_PROC;
        phase_n = 1'b0;
        clr     = 1'b1;
      end
      ST_PROC: if (!phase) begin
        phase_n = 1'b1;
      end else begin
        phase_n = 1'b0;
        if (at_end) begin
          st_n = ST_DISP;
          clr  = 1'b1;
        end else begin
          adv = 1'b1;
        end
      end
      ST_DISP: if (at_end) begin
        st_n = ST_IDLE;
        clr  = 1'b1;
      end else begin
        adv = 1'b1;
      end
      default: begin
        st_n    = ST_IDLE;
        phase_n = 1'b0;
        clr     = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      phase   <= 1'b0;
      mem_rd  <= 1'b0;
      mem_wr  <= 1'b0;
      proc_en <= 1'b0;
      enc_en  <= 1'b0;
    end else begin
      st      <= st_n;
      phase   <= phase_n;
      mem_rd  <= ((st_n == ST_PROC) && !phase_n) || (st_n == ST_DISP);
      mem_wr  <= (st_n == ST_PROC) && phase_n;
      proc_en <= (st_n == ST_PROC);
      enc_en  <= (st_n == ST_DISP);
    end
  end

  assign mem_addr    = {fld, line, col};
  assign sched_state = st;

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !(mem_rd || mem_wr || proc_en || enc_en));
  p_one_path_r2: assert property (@(posedge clk) disable iff (rst)
    !(proc_en && enc_en));
  p_wr_after_rd_r4: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> ($past(mem_rd) && $stable(mem_addr)));
  p_disp_read_only_r5: assert property (@(posedge clk) disable iff (rst)
    enc_en |-> (mem_rd && !mem_wr));
  p_start_r6: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_IDLE) && grant) |=> (proc_en && mem_addr == '0));
  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_PROC) && frame_sof) |=> (st != ST_IDLE));
endmodule

// File: tb/frame_sched_tb.sv
module frame_sched_tb;
  localparam int COLS   = 8;
  localparam int FL     = 3;
  localparam int COL_W  = 10;
  localparam int LINE_W = 8;
  localparam int AW     = 1 + LINE_W + COL_W;

  typedef struct packed {
    logic [1:0]    st;
    logic          rd, wr, pe, ee;
    logic [AW-1:0] addr;
  } item_t;

  logic clk = 1'b0, rst = 1'b1, frame_sof = 1'b0;
  logic [4:0] req_fps = '0;
  logic [AW-1:0] mem_addr;
  logic mem_rd, mem_wr, proc_en, enc_en;
  logic [1:0] sched_state;

  int errors = 0, checks = 0;
  int m_idx = 0, m_used = 0, starts = 0;
  logic prev_pe = 1'b0, done = 1'b0;
  item_t exp_q[$];
  item_t got, want;

  always #4 clk = ~clk;

  frame_sched #(.COLS(COLS), .FIELD_LINES(FL)) u_dut (
    .clk(clk), .rst(rst), .frame_sof(frame_sof), .req_fps(req_fps),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .proc_en(proc_en), .enc_en(enc_en), .sched_state(sched_state)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic item_t mk(input logic [1:0] s, input logic rd, input logic wr,
                               input int f, input int l, input int c);
    item_t it;
    it.st = s; it.rd = rd; it.wr = wr;
    it.pe = (s == 2'd1); it.ee = (s == 2'd2);
    it.addr = {f[0], l[LINE_W-1:0], c[COL_W-1:0]};
    return it;
  endfunction

  // R3/R4/R5: odd field first, column steps by 2, process = read then write
  task automatic push_frame();
    for (int f = 0; f < 2; f++)
      for (int l = 0; l < FL; l++)
        for (int c = 0; c < COLS; c += 2) begin
          exp_q.push_back(mk(2'd1, 1'b1, 1'b0, f, l, c));
          exp_q.push_back(mk(2'd1, 1'b0, 1'b1, f, l, c));
        end
    for (int f = 0; f < 2; f++)
      for (int l = 0; l < FL; l++)
        for (int c = 0; c < COLS; c += 2)
          exp_q.push_back(mk(2'd2, 1'b1, 1'b0, f, l, c));
  endtask

  // driver: R6-R10 model of the per-second budget
  task automatic send(input int req, input int gap);
    int base, cap;
    bit busy, acc;
    @(negedge clk);
    req_fps = 5'(req);
    frame_sof = 1'b1;
    base = (m_idx == 0) ? 0 : m_used;
    cap  = (req > 15) ? 15 : req;
    busy = (exp_q.size() != 0);
    acc  = !busy && (base < cap);
    m_used = base + (acc ? 1 : 0);
    m_idx  = (m_idx + 1) % 30;
    if (acc) push_frame();
    @(negedge clk);
    frame_sof = 1'b0;
    repeat (gap - 1) @(negedge clk);
  endtask

  task automatic second(input int req_a, input int req_b, input int split,
                        input int gap, input int exp_starts, input string tag);
    for (int i = 0; i < 30; i++) send((i < split) ? req_a : req_b, gap);
    repeat (100) @(negedge clk);
    chk(starts == exp_starts, tag, starts, exp_starts);
    starts = 0;
  endtask

  // monitor: pops expected items as strobes appear
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (proc_en && !prev_pe) starts++;
      prev_pe = proc_en;
      if (mem_rd || mem_wr || proc_en || enc_en) begin
        got = '{st: sched_state, rd: mem_rd, wr: mem_wr, pe: proc_en,
                ee: enc_en, addr: mem_addr};
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 unexpected activity", int'(sched_state), 0);
        end else begin
          want = exp_q.pop_front();
          chk(got.addr == want.addr, "R3 address", int'(got.addr), int'(want.addr));
          chk({got.st, got.rd, got.wr, got.pe, got.ee} ==
              {want.st, want.rd, want.wr, want.pe, want.ee},
              (want.st == 2'd1) ? "R4 process strobes" : "R5 display strobes",
              int'({got.st, got.rd, got.wr, got.pe, got.ee}),
              int'({want.st, want.rd, want.wr, want.pe, want.ee}));
        end
      end else begin
        chk(sched_state == 2'd0, "R2 idle state", int'(sched_state), 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk({sched_state, mem_rd, mem_wr, proc_en, enc_en} == '0, "R1 in reset",
        int'({sched_state, mem_rd, mem_wr, proc_en, enc_en}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk({sched_state, mem_rd, mem_wr, proc_en, enc_en} == '0 && mem_addr == '0,
        "R1 after reset", int'(mem_addr), 0);
    second(4, 4, 30, 100, 4, "R9 request 4");
    second(20, 20, 30, 100, 15, "R9 request 20 capped");
    second(0, 0, 30, 100, 0, "R10 zero request");
    second(15, 15, 30, 50, 15, "R7 busy strobes dropped");
    second(2, 6, 10, 100, 6, "R8 budget across request change");
    chk(exp_q.size() == 0, "R6 all granted frames walked", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule